// File: doc/BRIEF.md
# Multiply-Accumulate Accumulator Datapath

This block is the arithmetic core of a 16-bit signal processor. It keeps two signed 16-bit operand registers (X and Y), a 32-bit accumulator with zero and negative flags, and a 4-bit status mode field. A 32-bit product, always twice the signed product of X and Y, is formed continuously from the operand registers. It cannot be written directly.

On each clock edge where `op_valid` is high, the block runs one accumulator operation selected by `op_code`. The operations are:
- fused multiply-accumulate and multiply-subtract, which fold the current product into the accumulator and load fresh operands in the same step;
- clear-and-load;
- a full-width product-to-accumulator move;
- six short-immediate ALU operations;
- single-operand modifiers.

Operand fetch happens outside the block, which only receives the fetched X and Y values. A combinational condition tester compares the flags against a branch condition code.

Top module: `mac_acc_core`

## Requirements
- R1: A synchronous active-high reset clears X, Y, the accumulator, both flags and the status mode field. The product output then reads 0.
- R2: `p_out` equals the signed product of X and Y shifted left by one, truncated to 32 bits. It reflects new operands on the cycle after they are loaded. Op codes 1, 2 and 3 load X only, Y only, and both, from `x_in`/`y_in`.
- R3: Op code 4 (multiply-accumulate) adds the full 32-bit product present before the edge to the accumulator, updates Z and N, and loads X and Y from `x_in`/`y_in` on the same edge.
- R4: Op code 5 (multiply-subtract) subtracts the full 32-bit product present before the edge from the accumulator, updates Z and N, and loads X and Y on the same edge.
- R5: Op code 6 (clear-and-load) sets the accumulator to 0, clears the status mode field and loads X and Y. It leaves Z and N unchanged.
- R6: Op code 7 copies all 32 product bits into the accumulator and leaves Z and N unchanged.
- R7: Op code 8 applies the modifier in `mod_code`. Code 3 shifts the accumulator left by one. Code 6 negates it. Code 7 negates it only when bit 31 is set. Any other code leaves it unchanged. Every modifier code refreshes Z and N.
- R8: Op codes 9, 11, 12, 13 and 14 subtract, add, AND, OR and XOR the immediate into the accumulator and update Z and N. The immediate is `op_imm` zero-extended and placed at accumulator bits 23:16, with all other bits 0.
- R9: Op code 10 (compare) sets Z and N from the accumulator minus the aligned immediate and leaves the accumulator unchanged.
- R10: After any flag-updating operation, Z is 1 exactly when the 32-bit result is zero, and N equals result bit 31.
- R11: `acc_hi` presents accumulator bits 31:16 and `acc_lo` presents bits 15:0.
- R12: `cond_true` is 1 for condition code 8'h00. For 8'h50 it is 1 when Z equals `cond_val`. For 8'h70 it is 1 when N equals `cond_val`. For any other code it is 0.
- R13: Op code 15 loads the status mode field from `op_imm[3:0]` and changes nothing else. With `op_valid` low, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Execute `op_code` on this edge |
| op_code | input | 4 | Operation select |
| op_imm | input | 8 | Short immediate / mode value |
| mod_code | input | 3 | Single-operand modifier select |
| x_in | input | 16 | Fetched X operand |
| y_in | input | 16 | Fetched Y operand |
| cond_code | input | 8 | Branch condition code |
| cond_val | input | 1 | Expected flag value for the condition |
| x_out | output | 16 | X operand register |
| y_out | output | 16 | Y operand register |
| p_out | output | 32 | Doubled signed product |
| acc_hi | output | 16 | Accumulator bits 31:16 |
| acc_lo | output | 16 | Accumulator bits 15:0 |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| st_mode | output | 4 | Status mode field |
| cond_true | output | 1 | Condition result |

## Verification
A wrong operand register shows on `p_out` within the same cycle it is held. After the next fused operation, it also shows in the accumulator halves. A wrong accumulator or flag value is visible on `acc_hi`/`acc_lo`/`flag_z`/`flag_n` one edge after the faulty operation. It persists until an operation overwrites it, so a walked sequence in which each step depends on the last exposes a single bad step in every later row. Wrong flags also appear at once on `cond_true` for the zero and negative condition codes.

// File: rtl/mac_pkg.sv
package mac_pkg;

    localparam int DATA_W = 16;
    localparam int ACC_W  = 2 * DATA_W;
    localparam int IMM_W  = 8;
    localparam int MODE_W = 4;
    localparam int MODC_W = 3;
    localparam int CC_W   = 8;

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_LDX   = 4'd1,
        OP_LDY   = 4'd2,
        OP_LDXY  = 4'd3,
        OP_MAC   = 4'd4,
        OP_MSU   = 4'd5,
        OP_CLRLD = 4'd6,
        OP_MOVPA = 4'd7,
        OP_MOD   = 4'd8,
        OP_ISUB  = 4'd9,
        OP_ICMP  = 4'd10,
        OP_IADD  = 4'd11,
        OP_IAND  = 4'd12,
        OP_IOR   = 4'd13,
        OP_IXOR  = 4'd14,
        OP_SETST = 4'd15
    } acc_op_e;

    localparam logic [MODC_W-1:0] MOD_SHL = 3'd3;
    localparam logic [MODC_W-1:0] MOD_NEG = 3'd6;
    localparam logic [MODC_W-1:0] MOD_ABS = 3'd7;

    localparam logic [CC_W-1:0] CC_ALWAYS = 8'h00;
    localparam logic [CC_W-1:0] CC_ZERO   = 8'h50;
    localparam logic [CC_W-1:0] CC_NEG    = 8'h70;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             z;
        logic             n;
        logic             wr_acc;
        logic             wr_flags;
    } alu_res_t;

    typedef struct packed {
        logic [DATA_W-1:0] x;
        logic [DATA_W-1:0] y;
        logic [ACC_W-1:0]  acc;
        logic              z;
        logic              n;
        logic [MODE_W-1:0] mode;
    } core_state_t;

    // Place the short immediate just above the low data half.
    function automatic logic [ACC_W-1:0] align_imm(input logic [IMM_W-1:0] imm);
        return {{(ACC_W-IMM_W-DATA_W){1'b0}}, imm, {DATA_W{1'b0}}};
    endfunction

    function automatic logic is_zero(input logic [ACC_W-1:0] v);
        return (v == '0);
    endfunction

    function automatic logic loads_xy(input acc_op_e op);
        return (op == OP_LDXY) || (op == OP_MAC) || (op == OP_MSU) || (op == OP_CLRLD);
    endfunction

endpackage

// File: rtl/mac_product.sv
module mac_product
    import mac_pkg::*;
#(
    parameter int OPW = DATA_W
) (
    input  logic [OPW-1:0]   x,
    input  logic [OPW-1:0]   y,
    output logic [2*OPW-1:0] p
);
    localparam int PW = 2 * OPW;

    logic signed [PW-1:0] xs;
    logic signed [PW-1:0] ys;
    logic signed [PW-1:0] prod;

    // Sign-extend both operands to full width; the low PW bits of the
    // product are exact for a signed OPW x OPW multiply.
    assign xs   = {{OPW{x[OPW-1]}}, x};
    assign ys   = {{OPW{y[OPW-1]}}, y};
    assign prod = xs * ys;
    assign p    = {prod[PW-2:0], 1'b0};

endmodule

// File: rtl/mac_alu.sv
module mac_alu
    import mac_pkg::*;
(
    input  acc_op_e             op,
    input  logic [MODC_W-1:0]   mod_sel,
    input  logic [IMM_W-1:0]    imm,
    input  logic [ACC_W-1:0]    acc,
    input  logic [ACC_W-1:0]    prod,
    output alu_res_t            res
);
    logic [ACC_W-1:0] imm_ext;
    logic [ACC_W-1:0] mod_val;
    logic [ACC_W-1:0] result;
    logic [ACC_W-1:0] neg_acc;

    assign imm_ext = align_imm(imm);
    assign neg_acc = '0 - acc;

    always_comb begin
        case (mod_sel)
            MOD_SHL: mod_val = {acc[ACC_W-2:0], 1'b0};
            MOD_NEG: mod_val = neg_acc;
            MOD_ABS: mod_val = acc[ACC_W-1] ? neg_acc : acc;
            default: mod_val = acc;
        endcase
    end

    always_comb begin
        result       = acc;
        res.wr_acc   = 1'b0;
        res.wr_flags = 1'b0;
        case (op)
            OP_MAC:   begin result = acc + prod;    res.wr_acc = 1'b1; res.wr_flags = 1'b1; end
            OP_MSU:   begin result = acc - prod;    res.wr_acc = 1'b1; res.wr_flags = 1'b1; end
            OP_CLRLD: begin result = '0;            res.wr_acc = 1'b1; end
            OP_MOVPA: begin result = prod;          res.wr_acc = 1'b1; end
            OP_MOD:   begin result = mod_val;       res.wr_acc = 1'b1; res.wr_flags = 1'b1; end
            OP_ISUB:  begin result = acc - imm_ext; res.wr_acc = 1'b1; res.wr_flags = 1'b1; end
            OP_ICMP:  begin result = acc - imm_ext; res.wr_flags = 1'b1; end
            OP_IADD:  begin result = acc + imm_ext; res.wr_acc = 1'b1; res.wr_flags = 1'b1; end
            OP_IAND:  begin result = acc & imm_ext; res.wr_acc = 1'b1; res.wr_flags = 1'b1; end
            OP_IOR:   begin result = acc | imm_ext; res.wr_acc = 1'b1; res.wr_flags = 1'b1; end
            OP_IXOR:  begin result = acc ^ imm_ext; res.wr_acc = 1'b1; res.wr_flags = 1'b1; end
            default:  begin result = acc; end
        endcase
        res.acc = result;
        res.z   = is_zero(result);
        res.n   = result[ACC_W-1];
    end

endmodule

// File: rtl/mac_cond.sv
module mac_cond
    import mac_pkg::*;
#(
    parameter int CW = CC_W
) (
    input  logic [CW-1:0] code,
    input  logic          val,
    input  logic          z,
    input  logic          n,
    output logic          hit
);
    always_comb begin
        case (code)
            CW'(CC_ALWAYS): hit = 1'b1;
            CW'(CC_ZERO):   hit = (z == val);
            CW'(CC_NEG):    hit = (n == val);
            default:        hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/mac_acc_core.sv
module mac_acc_core
    import mac_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                op_valid,
    input  logic [3:0]          op_code,
    input  logic [IMM_W-1:0]    op_imm,
    input  logic [MODC_W-1:0]   mod_code,
    input  logic [DATA_W-1:0]   x_in,
    input  logic [DATA_W-1:0]   y_in,
    input  logic [CC_W-1:0]     cond_code,
    input  logic                cond_val,
    output logic [DATA_W-1:0]   x_out,
    output logic [DATA_W-1:0]   y_out,
    output logic [ACC_W-1:0]    p_out,
    output logic [DATA_W-1:0]   acc_hi,
    output logic [DATA_W-1:0]   acc_lo,
    output logic                flag_z,
    output logic                flag_n,
    output logic [MODE_W-1:0]   st_mode,
    output logic                cond_true
);
    acc_op_e     op;
    core_state_t st_q;
    core_state_t st_d;
    alu_res_t    alu;
    logic [ACC_W-1:0] prod;

    assign op = acc_op_e'(op_code);

    mac_product #(.OPW(DATA_W)) u_prod (
        .x (st_q.x),
        .y (st_q.y),
        .p (prod)
    );

    mac_alu u_alu (
        .op      (op),
        .mod_sel (mod_code),
        .imm     (op_imm),
        .acc     (st_q.acc),
        .prod    (prod),
        .res     (alu)
    );

    mac_cond #(.CW(CC_W)) u_cond (
        .code (cond_code),
        .val  (cond_val),
        .z    (st_q.z),
        .n    (st_q.n),
        .hit  (cond_true)
    );

    always_comb begin
        st_d = st_q;
        if (op_valid) begin
            if (op == OP_LDX || loads_xy(op)) st_d.x = x_in;
            if (op == OP_LDY || loads_xy(op)) st_d.y = y_in;
            if (alu.wr_acc)   st_d.acc = alu.acc;
            if (alu.wr_flags) begin
                st_d.z = alu.z;
                st_d.n = alu.n;
            end
            if (op == OP_CLRLD)      st_d.mode = '0;
            else if (op == OP_SETST) st_d.mode = op_imm[MODE_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign x_out   = st_q.x;
    assign y_out   = st_q.y;
    assign p_out   = prod;
    assign acc_hi  = st_q.acc[ACC_W-1:DATA_W];
    assign acc_lo  = st_q.acc[DATA_W-1:0];
    assign flag_z  = st_q.z;
    assign flag_n  = st_q.n;
    assign st_mode = st_q.mode;

    logic [ACC_W-1:0] acc_now;
    assign acc_now = {acc_hi, acc_lo};

    AST_XY_LOAD: assert property (@(posedge clk) disable iff (rst)
        (op_valid && loads_xy(op)) |=> (x_out == $past(x_in) && y_out == $past(y_in))); // R3
    AST_MAC_SUM: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op == OP_MAC) |=> (acc_now == $past(acc_now) + $past(p_out))); // R3
    AST_MSU_DIFF: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op == OP_MSU) |=> (acc_now == $past(acc_now) - $past(p_out))); // R4
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op == OP_CLRLD) |=> (acc_now == '0 && st_mode == '0 && $stable(flag_z) && $stable(flag_n))); // R5
    AST_MOVE_P: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op == OP_MOVPA) |=> (acc_now == $past(p_out))); // R6
    AST_CMP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op == OP_ICMP) |=> $stable(acc_now)); // R9
    AST_FLAG_MATCH: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op == OP_MAC || op == OP_MSU || op == OP_MOD || op == OP_ISUB ||
                      op == OP_IADD || op == OP_IAND || op == OP_IOR || op == OP_IXOR))
        |=> (flag_z == (acc_now == '0) && flag_n == acc_now[ACC_W-1])); // R10
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> ($stable(acc_now) && $stable(x_out) && $stable(y_out) && $stable(st_mode))); // R13
    AST_COND_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cond_code == CC_ZERO) |-> (cond_true == (flag_z == cond_val))); // R12

endmodule

// File: tb/mac_acc_core_tb.sv
module mac_acc_core_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 23;

    typedef struct packed {
        logic [3:0]  op;
        logic [7:0]  imm;
        logic [2:0]  md;
        logic [15:0] x;
        logic [15:0] y;
        logic [31:0] acc;
        logic        z;
        logic        n;
        logic [31:0] p;
    } vec_t;

    // Op codes per R2..R9: 3 load both, 4 mac, 5 msu, 6 clear-load, 7 move P,
    // 8 modifier, 9 sub, 10 cmp, 11 add, 12 and, 13 or, 14 xor.
    localparam vec_t VEC [NVEC] = '{
        '{4'd3,  8'h00, 3'd0, 16'h0003, 16'h0005, 32'h00000000, 1'b0, 1'b0, 32'h0000001E},
        '{4'd4,  8'h00, 3'd0, 16'hFFFE, 16'h0007, 32'h0000001E, 1'b0, 1'b0, 32'hFFFFFFE4},
        '{4'd4,  8'h00, 3'd0, 16'h4000, 16'h4000, 32'h00000002, 1'b0, 1'b0, 32'h20000000},
        '{4'd5,  8'h00, 3'd0, 16'h0001, 16'h0001, 32'hE0000002, 1'b0, 1'b1, 32'h00000002},
        '{4'd7,  8'h00, 3'd0, 16'h0000, 16'h0000, 32'h00000002, 1'b0, 1'b1, 32'h00000002},
        '{4'd11, 8'h80, 3'd0, 16'h0000, 16'h0000, 32'h00800002, 1'b0, 1'b0, 32'h00000002},
        '{4'd10, 8'h80, 3'd0, 16'h0000, 16'h0000, 32'h00800002, 1'b0, 1'b0, 32'h00000002},
        '{4'd10, 8'h81, 3'd0, 16'h0000, 16'h0000, 32'h00800002, 1'b0, 1'b1, 32'h00000002},
        '{4'd14, 8'hFF, 3'd0, 16'h0000, 16'h0000, 32'h007F0002, 1'b0, 1'b0, 32'h00000002},
        '{4'd13, 8'h80, 3'd0, 16'h0000, 16'h0000, 32'h00FF0002, 1'b0, 1'b0, 32'h00000002},
        '{4'd12, 8'h0F, 3'd0, 16'h0000, 16'h0000, 32'h000F0000, 1'b0, 1'b0, 32'h00000002},
        '{4'd9,  8'h10, 3'd0, 16'h0000, 16'h0000, 32'hFFFF0000, 1'b0, 1'b1, 32'h00000002},
        '{4'd8,  8'h00, 3'd6, 16'h0000, 16'h0000, 32'h00010000, 1'b0, 1'b0, 32'h00000002},
        '{4'd8,  8'h00, 3'd3, 16'h0000, 16'h0000, 32'h00020000, 1'b0, 1'b0, 32'h00000002},
        '{4'd9,  8'h02, 3'd0, 16'h0000, 16'h0000, 32'h00000000, 1'b1, 1'b0, 32'h00000002},
        '{4'd8,  8'h00, 3'd7, 16'h0000, 16'h0000, 32'h00000000, 1'b1, 1'b0, 32'h00000002},
        '{4'd9,  8'h01, 3'd0, 16'h0000, 16'h0000, 32'hFFFF0000, 1'b0, 1'b1, 32'h00000002},
        '{4'd8,  8'h00, 3'd7, 16'h0000, 16'h0000, 32'h00010000, 1'b0, 1'b0, 32'h00000002},
        '{4'd6,  8'h00, 3'd0, 16'h8000, 16'h8000, 32'h00000000, 1'b0, 1'b0, 32'h80000000},
        '{4'd8,  8'h00, 3'd5, 16'h0000, 16'h0000, 32'h00000000, 1'b1, 1'b0, 32'h80000000},
        '{4'd7,  8'h00, 3'd0, 16'h0000, 16'h0000, 32'h80000000, 1'b1, 1'b0, 32'h80000000},
        '{4'd8,  8'h00, 3'd7, 16'h0000, 16'h0000, 32'h80000000, 1'b0, 1'b1, 32'h80000000},
        '{4'd8,  8'h00, 3'd3, 16'h0000, 16'h0000, 32'h00000000, 1'b1, 1'b0, 32'h80000000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic [7:0]  op_imm = '0;
    logic [2:0]  mod_code = '0;
    logic [15:0] x_in = '0;
    logic [15:0] y_in = '0;
    logic [7:0]  cond_code = '0;
    logic        cond_val = 1'b0;
    logic [15:0] x_out, y_out, acc_hi, acc_lo;
    logic [31:0] p_out;
    logic        flag_z, flag_n, cond_true;
    logic [3:0]  st_mode;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mac_acc_core dut_i (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .op_imm(op_imm), .mod_code(mod_code), .x_in(x_in), .y_in(y_in),
        .cond_code(cond_code), .cond_val(cond_val),
        .x_out(x_out), .y_out(y_out), .p_out(p_out), .acc_hi(acc_hi),
        .acc_lo(acc_lo), .flag_z(flag_z), .flag_n(flag_n),
        .st_mode(st_mode), .cond_true(cond_true)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] op, input logic [7:0] imm, input logic [2:0] md,
                         input logic [15:0] x, input logic [15:0] y, input logic vld);
        @(negedge clk);
        op_valid = vld; op_code = op; op_imm = imm; mod_code = md; x_in = x; y_in = y;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 reset acc/flags/mode", {acc_hi, acc_lo, flag_z, flag_n, st_mode}, '0);
        check("R1 reset x/y/p", {x_out, y_out, p_out}, '0);

        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i].op, VEC[i].imm, VEC[i].md, VEC[i].x, VEC[i].y, 1'b1);
            // R3 R4 R6 R7 R8 R9 R10 R11: accumulator halves and flags
            check($sformatf("R8/R10 row %0d acc,z,n (R11 halves)", i),
                  {acc_hi, acc_lo, flag_z, flag_n}, {VEC[i].acc, VEC[i].z, VEC[i].n});
            // R2 doubled product follows the operand registers
            check($sformatf("R2 row %0d product", i), p_out, VEC[i].p);
        end

        // R3 fused load of operands observed on last loaded values
        check("R3 operand registers", {x_out, y_out}, {16'h8000, 16'h8000});

        // R13 op_valid low: nothing changes
        apply(4'd4, 8'h00, 3'd0, 16'h1234, 16'h5678, 1'b0);
        check("R13 idle holds state", {x_out, y_out, acc_hi, acc_lo, flag_z, flag_n},
              {16'h8000, 16'h8000, 32'h0, 1'b1, 1'b0});

        // R13 mode load changes only the mode field
        apply(4'd15, 8'h5A, 3'd0, 16'h1111, 16'h2222, 1'b1);
        check("R13 mode load", st_mode, 4'hA);
        check("R13 mode load side effects", {x_out, y_out, acc_hi, acc_lo, flag_z, flag_n},
              {16'h8000, 16'h8000, 32'h0, 1'b1, 1'b0});

        // R12 condition codes with Z=1, N=0
        @(negedge clk);
        cond_code = 8'h00; cond_val = 1'b0; #1 check("R12 always", cond_true, 1'b1);
        cond_code = 8'h50; cond_val = 1'b1; #1 check("R12 zero match", cond_true, 1'b1);
        cond_code = 8'h50; cond_val = 1'b0; #1 check("R12 zero mismatch", cond_true, 1'b0);
        cond_code = 8'h70; cond_val = 1'b0; #1 check("R12 neg match", cond_true, 1'b1);
        cond_code = 8'h70; cond_val = 1'b1; #1 check("R12 neg mismatch", cond_true, 1'b0);
        cond_code = 8'h30; cond_val = 1'b1; #1 check("R12 unknown code", cond_true, 1'b0);
        cond_code = 8'h00;

        // R5 clear-and-load clears mode, loads X/Y, keeps flags
        apply(4'd6, 8'h00, 3'd0, 16'h0002, 16'h0003, 1'b1);
        check("R5 clear-load mode/acc/flags", {st_mode, acc_hi, acc_lo, flag_z, flag_n},
              {4'h0, 32'h0, 1'b1, 1'b0});
        check("R5 clear-load operands/product", {x_out, y_out, p_out},
              {16'h0002, 16'h0003, 32'h0000000C});

        // R1 reset mid-run
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check("R1 reset after activity", {x_out, y_out, p_out, acc_hi, acc_lo, flag_z, flag_n, st_mode}, '0);

        finish_run();
    end

endmodule